// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a 32-bit physical address. It reads a two-level page table held in ordinary memory and has no translation cache. A request names the logical address. The walker then reads the top-level entry, which gives the base of a low-level table, and then reads the leaf entry, which gives the physical frame. The result is either the physical address or a fault that says which level held an invalid entry. A successful translation therefore costs two table reads before the data access itself can start.

The root of the table comes from a page table base register. The operating system loads this register through its own write port when it switches processes. Each write carries a privilege flag. A write made outside system mode changes nothing and is reported on a one-cycle violation flag.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault`, `mem_req_valid` and `priv_viol` are low, and the base register holds zero.
- R2: The walker reads the top-level entry at word address {base[31:12], laddr[31:22], 2'b00}. This is the table base plus the top index times 4.
- R3: If the top entry has bit 0 set, the walker next reads the leaf entry at {top_entry[31:12], laddr[21:12], 2'b00}.
- R4: If the leaf entry has bit 0 set, `done` pulses for one cycle. In that cycle `paddr` equals {leaf_entry[31:12], laddr[11:0]}.
- R5: If the top entry has bit 0 clear, `fault` pulses with `fault_level` = 0. No leaf read is issued, so the walk makes exactly one memory read.
- R6: If the leaf entry has bit 0 clear, `fault` pulses with `fault_level` = 1. Bits 31:1 of that entry have no effect.
- R7: A memory read request stays asserted, with a stable address, until the cycle in which `mem_req_ready` is high.
- R8: A base write with `base_wr_sys` = 1 takes effect for the next walk. Bits 11:0 of the written value are discarded.
- R9: A base write with `base_wr_sys` = 0 leaves the base register unchanged. It raises `priv_viol` for exactly the one cycle after the write.
- R10: The walker accepts `req_valid` only while `busy` is low. A request presented during a walk is ignored and causes no extra memory read and no extra result.
- R11: `done` and `fault` never occur together. Each lasts one cycle, and `busy` is low in the cycle after either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_laddr | input | 32 | Logical address to translate |
| busy | output | 1 | High from acceptance through the done or fault cycle |
| done | output | 1 | One-cycle pulse when a translation succeeds |
| fault | output | 1 | One-cycle pulse when a walk hits an invalid entry |
| fault_level | output | 1 | Level of the invalid entry (0 top, 1 leaf) |
| paddr | output | 32 | Physical address, valid while `done` is high |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data is returned |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| base_wr_en | input | 1 | Base register write strobe |
| base_wr_sys | input | 1 | Writer is in system mode |
| base_wr_data | input | 32 | New table base (bits 31:12 kept) |
| priv_viol | output | 1 | One-cycle flag for a rejected base write |

## Verification
The checks assume that memory returns exactly one response for each accepted read, and never returns one while no read is outstanding. The bench memory model produces a response one cycle after every handshake, and it lowers `mem_req_ready` on a fixed stall pattern so that requests are held across several cycles. The checks also assume that a base write never lands in the same cycle a request is accepted. The bench issues base writes only while the walker is idle and no request is being driven.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W     = 32;
  localparam int PAGE_W     = 12;
  localparam int IDX_W      = 10;
  localparam int NUM_LEVELS = 2;
  localparam int FRAME_W    = ADDR_W - PAGE_W;
  localparam int PAD_W      = ADDR_W - FRAME_W - IDX_W;
  localparam int LVL_W      = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1;
  localparam int VALID_BIT  = 0;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_READ_TOP  = 3'd1,
    ST_READ_LEAF = 3'd2,
    ST_DONE      = 3'd3,
    ST_FAULT     = 3'd4
  } walk_state_e;
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg
  import ptw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_sys,
  input  logic [ADDR_W-1:0]   wr_data,
  output logic [FRAME_W-1:0]  base_frame,
  output logic                priv_viol
);
  logic               base_ld;
  logic [FRAME_W-1:0] base_d;
  logic               viol_d;

  always_comb begin
    base_ld = wr_en & wr_sys;
    base_d  = wr_data[ADDR_W-1:PAGE_W];
    viol_d  = wr_en & ~wr_sys;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_frame <= '0;
    end else if (base_ld) begin
      base_frame <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_viol <= 1'b0;
    end else begin
      priv_viol <= viol_d;
    end
  end
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
  import ptw_pkg::*;
(
  input  logic [FRAME_W-1:0] tbl_base,
  input  logic [IDX_W-1:0]   tbl_idx,
  output logic [ADDR_W-1:0]  entry_addr
);
  always_comb begin
    entry_addr = {tbl_base, tbl_idx, {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  input  logic [ADDR_W-1:0]                req_laddr,
  input  logic [FRAME_W-1:0]               base_frame,
  input  logic [NUM_LEVELS-1:0][ADDR_W-1:0] lvl_addr,
  output logic [NUM_LEVELS-1:0][FRAME_W-1:0] lvl_base,
  output logic [NUM_LEVELS-1:0][IDX_W-1:0]  lvl_idx,
  input  logic                             mem_req_ready,
  input  logic                             mem_rsp_valid,
  input  logic [ADDR_W-1:0]                mem_rsp_data,
  output logic                             mem_req_valid,
  output logic [ADDR_W-1:0]                mem_req_addr,
  output logic                             busy,
  output logic                             done,
  output logic                             fault,
  output logic [LVL_W-1:0]                 fault_level,
  output logic [ADDR_W-1:0]                paddr
);
  walk_state_e        state_q, state_d;
  logic               pend_q, pend_d;
  logic               ld_req, ld_leaf, ld_frame, ld_flvl;
  logic [LVL_W-1:0]   flvl_d;
  logic [ADDR_W-1:0]  laddr_q;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] leaf_q;
  logic [FRAME_W-1:0] frame_q;
  logic [LVL_W-1:0]   flvl_q;
  logic               rsp_take;
  logic               entry_ok;

  always_comb begin
    rsp_take = ~pend_q & mem_rsp_valid;
    entry_ok = mem_rsp_data[VALID_BIT];
  end

  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    ld_req   = 1'b0;
    ld_leaf  = 1'b0;
    ld_frame = 1'b0;
    ld_flvl  = 1'b0;
    flvl_d   = flvl_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_READ_TOP;
          pend_d  = 1'b1;
          ld_req  = 1'b1;
        end
      end
      ST_READ_TOP: begin
        if (pend_q) begin
          if (mem_req_ready) pend_d = 1'b0;
        end else if (rsp_take) begin
          if (entry_ok) begin
            state_d = ST_READ_LEAF;
            pend_d  = 1'b1;
            ld_leaf = 1'b1;
          end else begin
            state_d = ST_FAULT;
            ld_flvl = 1'b1;
            flvl_d  = LVL_W'(0);
          end
        end
      end
      ST_READ_LEAF: begin
        if (pend_q) begin
          if (mem_req_ready) pend_d = 1'b0;
        end else if (rsp_take) begin
          if (entry_ok) begin
            state_d  = ST_DONE;
            ld_frame = 1'b1;
          end else begin
            state_d = ST_FAULT;
            ld_flvl = 1'b1;
            flvl_d  = LVL_W'(1);
          end
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      laddr_q <= '0;
      root_q  <= '0;
    end else if (ld_req) begin
      laddr_q <= req_laddr;
      root_q  <= base_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leaf_q <= '0;
    end else if (ld_leaf) begin
      leaf_q <= mem_rsp_data[ADDR_W-1:PAGE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (ld_frame) begin
      frame_q <= mem_rsp_data[ADDR_W-1:PAGE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flvl_q <= '0;
    end else if (ld_flvl) begin
      flvl_q <= flvl_d;
    end
  end

  always_comb begin
    lvl_base[0] = root_q;
    lvl_base[1] = leaf_q;
    lvl_idx[0]  = laddr_q[ADDR_W-1 -: IDX_W];
    lvl_idx[1]  = laddr_q[PAGE_W +: IDX_W];
  end

  always_comb begin
    mem_req_valid = pend_q & ((state_q == ST_READ_TOP) | (state_q == ST_READ_LEAF));
    mem_req_addr  = (state_q == ST_READ_LEAF) ? lvl_addr[1] : lvl_addr[0];
    busy          = (state_q != ST_IDLE);
    done          = (state_q == ST_DONE);
    fault         = (state_q == ST_FAULT);
    fault_level   = flvl_q;
    paddr         = {frame_q, laddr_q[PAGE_W-1:0]};
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_laddr,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              fault_level,
  output logic [31:0]       paddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  input  logic              base_wr_en,
  input  logic              base_wr_sys,
  input  logic [31:0]       base_wr_data,
  output logic              priv_viol
);
  logic [FRAME_W-1:0]                 base_frame;
  logic [NUM_LEVELS-1:0][FRAME_W-1:0] lvl_base;
  logic [NUM_LEVELS-1:0][IDX_W-1:0]   lvl_idx;
  logic [NUM_LEVELS-1:0][ADDR_W-1:0]  lvl_addr;

  ptw_base_reg u_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (base_wr_en),
    .wr_sys     (base_wr_sys),
    .wr_data    (base_wr_data),
    .base_frame (base_frame),
    .priv_viol  (priv_viol)
  );

  for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_lvl
    ptw_entry_addr u_addr (
      .tbl_base   (lvl_base[lv]),
      .tbl_idx    (lvl_idx[lv]),
      .entry_addr (lvl_addr[lv])
    );
  end

  ptw_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_laddr     (req_laddr),
    .base_frame    (base_frame),
    .lvl_addr      (lvl_addr),
    .lvl_base      (lvl_base),
    .lvl_idx       (lvl_idx),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .busy          (busy),
    .done          (done),
    .fault         (fault),
    .fault_level   (fault_level),
    .paddr         (paddr)
  );
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_laddr,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic [31:0] paddr,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        base_wr_en,
  input logic        base_wr_sys,
  input logic        priv_viol
);
  logic [11:0] offs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offs_q <= '0;
    end else if (req_valid && !busy) begin
      offs_q <= req_laddr[11:0];
    end
  end

  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault)); // R11
  AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !busy); // R11
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R7
  AST_READ_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy); // R10
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (paddr[11:0] == offs_q)); // R4
  AST_PRIV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    priv_viol |-> $past(base_wr_en && !base_wr_sys)); // R9
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_laddr     (req_laddr),
  .busy          (busy),
  .done          (done),
  .fault         (fault),
  .paddr         (paddr),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .base_wr_en    (base_wr_en),
  .base_wr_sys   (base_wr_sys),
  .priv_viol     (priv_viol)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
  typedef struct packed {
    logic        flt;
    logic        lvl;
    logic [31:0] pa;
  } res_t;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_laddr;
  logic        busy, done, fault, fault_level, priv_viol;
  logic [31:0] paddr;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data;
  logic        base_wr_en, base_wr_sys;
  logic [31:0] base_wr_data;

  int          checks = 0;
  int          failures = 0;
  logic [31:0] mem_img [int unsigned];
  logic [31:0] rd_q [$];
  res_t        res_q [$];
  logic [31:0] base_model;
  int          stall_cnt;

  ptw_walker dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem_img.exists(a) ? mem_img[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    stall_cnt     = 0;
    forever begin
      @(posedge clk);
      mem_rsp_valid <= mem_req_valid & mem_req_ready & rst_n;
      mem_rsp_data  <= mem_rd(mem_req_addr);
      mem_req_ready <= rst_n && ((stall_cnt % 3) != 0);
      stall_cnt++;
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (mem_req_valid && mem_req_ready) begin
          if (rd_q.size() == 0) begin
            check(1'b0, "R5/R10 unexpected read", mem_req_addr, 32'h0);
          end else begin
            logic [31:0] ea;
            ea = rd_q.pop_front();
            check(mem_req_addr == ea, "R2/R3/R8 read address", mem_req_addr, ea);
          end
        end
        if (done || fault) begin
          if (res_q.size() == 0) begin
            check(1'b0, "R10 unexpected result", {31'h0, fault}, 32'h0);
          end else begin
            res_t er;
            er = res_q.pop_front();
            check(fault == er.flt, "R5/R6 fault flag", {31'h0, fault}, {31'h0, er.flt});
            if (er.flt) check(fault_level == er.lvl, "R5/R6 fault level", {31'h0, fault_level}, {31'h0, er.lvl});
            else        check(paddr == er.pa, "R4 physical address", paddr, er.pa);
          end
        end
      end
    end
  end

  task automatic translate(input logic [31:0] la, input bit poke);
    logic [31:0] ta, te, lea, le;
    res_t r;
    ta = {base_model[31:12], la[31:22], 2'b00};
    rd_q.push_back(ta);
    te = mem_rd(ta);
    if (!te[0]) begin
      r = '{flt: 1'b1, lvl: 1'b0, pa: 32'h0};
    end else begin
      lea = {te[31:12], la[21:12], 2'b00};
      rd_q.push_back(lea);
      le = mem_rd(lea);
      if (!le[0]) r = '{flt: 1'b1, lvl: 1'b1, pa: 32'h0};
      else        r = '{flt: 1'b0, lvl: 1'b0, pa: {le[31:12], la[11:0]}};
    end
    res_q.push_back(r);
    @(negedge clk);
    req_valid = 1'b1;
    req_laddr = la;
    @(negedge clk);
    check(busy == 1'b1, "R10 busy after accept", {31'h0, busy}, 32'h1);
    if (poke) begin
      req_laddr = ~la;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic base_write(input logic [31:0] d, input bit sys);
    @(negedge clk);
    base_wr_en   = 1'b1;
    base_wr_sys  = sys;
    base_wr_data = d;
    @(negedge clk);
    base_wr_en = 1'b0;
    check(priv_viol == !sys, "R9 violation flag", {31'h0, priv_viol}, {31'h0, !sys});
    if (sys) base_model = {d[31:12], 12'h0};
    @(negedge clk);
    check(priv_viol == 1'b0, "R9 flag one cycle", {31'h0, priv_viol}, 32'h0);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_laddr = '0;
    base_wr_en = 1'b0;
    base_wr_sys = 1'b0;
    base_wr_data = '0;
    base_model = '0;
    mem_img[32'h0000_000C] = 32'h0000_7001;
    mem_img[32'h0000_7014] = 32'h1234_5001;
    mem_img[32'h0001_0004] = 32'h0002_0001;
    mem_img[32'h0002_000C] = 32'hABCD_E001;
    mem_img[32'h0002_0010] = 32'hFFFF_FFFE;
    mem_img[32'h0001_0FFC] = 32'h0003_0001;
    mem_img[32'h0003_0FFC] = 32'h00AB_C001;
    mem_img[32'h0006_0004] = 32'h0004_0001;
    mem_img[32'h0004_000C] = 32'h5555_5001;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", {31'h0, busy}, 32'h0);
    check(done == 1'b0, "R1 done", {31'h0, done}, 32'h0);
    check(fault == 1'b0, "R1 fault", {31'h0, fault}, 32'h0);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
    check(priv_viol == 1'b0, "R1 priv_viol", {31'h0, priv_viol}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    translate(32'h00C0_5ABC, 1'b0);   // R1 zero base, R2/R3/R4
    base_write(32'h0001_0ABC, 1'b1);  // R8 low bits dropped
    translate(32'h0040_3123, 1'b0);   // R4
    translate(32'h0080_0FFF, 1'b0);   // R5 top invalid
    translate(32'h0040_4000, 1'b0);   // R6 leaf invalid, junk bits
    translate(32'hFFFF_FFFF, 1'b0);   // R2/R3 max indices
    base_write(32'h0005_0000, 1'b0);  // R9 ignored
    translate(32'h0040_3123, 1'b1);   // R9 old base kept, R10 poke
    base_write(32'h0006_0000, 1'b1);  // R8 new process
    translate(32'h0040_3123, 1'b0);
    translate(32'h0080_0FFF, 1'b1);   // R10 during fault walk
    repeat (4) @(negedge clk);
    check(rd_q.size() == 0, "R5 read count", rd_q.size(), 32'h0);
    check(res_q.size() == 0, "R11 result count", res_q.size(), 32'h0);
    check(busy == 1'b0, "R11 idle at end", {31'h0, busy}, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule